// File: doc/BRIEF.md
# Low-Power Idle Acknowledgment Controller

This block decides when a peripheral may answer a system power controller's idle request. A two-bit policy field, held in a configuration register, selects one of three defined behaviours. Under the forced policy, the block grants idle on any request. Under the never policy, it refuses every request. Under the smart policy, it waits until every interrupt output of the peripheral has been cleared before it grants idle.

When idle is granted, the block raises its acknowledge output. In the same cycle it raises an idle state flag, which the surrounding logic uses to gate the peripheral's clock. Once idle is granted, the block holds it until the power controller withdraws its request. One clock after the request is withdrawn, both outputs fall. The configuration register is loaded through a plain write strobe with a data word, and only bits [3:2] of that word are used.

Top module: `idle_ack_ctrl`

## Requirements
- R1: After reset, idle_ack_o and idle_o are 0 and the policy field holds 1 (never idle).
- R2: A write with cfg_we_i=1 loads the policy from cfg_wdata_i[3:2] at that clock edge. All other bits of cfg_wdata_i have no effect.
- R3: With policy 0 (forced), a request seen at a clock edge raises idle_ack_o and idle_o after that edge, even when interrupts are still asserted.
- R4: With policy 1 (never), idle_ack_o stays 0 whatever the request and the interrupts do.
- R5: With policy 2 (smart), a pending request is granted only at an edge where every bit of irq_i is 0. While any bit is 1, the request is not granted.
- R6: Policy 3 behaves like policy 1: a request is never granted.
- R7: While idle_req_i is 0 at a clock edge, both outputs are 0 after that edge.
- R8: Once idle is granted, it stays granted for as long as idle_req_i stays 1. Changes to the policy or to the interrupts do not drop it.
- R9: A policy written at an edge governs the grant decision from the next edge on. A request that is already waiting is then judged under the new policy.
- R10: idle_o always equals idle_ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | CFG_W | Configuration write data; policy in bits [3:2] |
| idle_req_i | input | 1 | Idle request from the power controller |
| irq_i | input | N_IRQ | Asserted interrupt outputs of the peripheral |
| idle_ack_o | output | 1 | Idle acknowledge to the power controller |
| idle_o | output | 1 | Idle state flag for clock gating |

## Verification
The assertions assume that the request, the interrupt vector and the write port are all stable around the rising edge. They also assume that the power controller may drop its request at any time, including while a grant is pending. The bench drives every input on the falling edge, so each value is settled well before the edge that samples it. The stimulus deliberately withdraws and re-raises requests in all four policies, changes the policy while a request waits and while idle is held, and raises interrupts after a grant. All of these cases stay inside the protocol the properties assume.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int unsigned POLICY_LSB = 2;
  localparam int unsigned POLICY_W   = 2;

  typedef enum logic [POLICY_W-1:0] {
    POL_FORCE = 2'd0,
    POL_NEVER = 2'd1,
    POL_SMART = 2'd2,
    POL_RSVD  = 2'd3
  } policy_e;
endpackage

// File: rtl/idle_cfg_reg.sv
module idle_cfg_reg
  import idle_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output policy_e          policy_o
);
  policy_e policy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   policy_q <= POL_NEVER;
    else if (we_i) policy_q <= policy_e'(wdata_i[POLICY_LSB +: POLICY_W]);
  end

  assign policy_o = policy_q;

  a_r2_field_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (policy_o == $past(wdata_i[POLICY_LSB +: POLICY_W])));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(policy_o));
endmodule

// File: rtl/idle_irq_quiet.sv
module idle_irq_quiet #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_i,
  output logic             quiet_o
);
  logic [N_IRQ:0] chain;

  assign chain[0] = 1'b1;
  for (genvar g = 0; g < N_IRQ; g++) begin : g_chain
    assign chain[g+1] = chain[g] & ~irq_i[g];
  end
  assign quiet_o = chain[N_IRQ];
endmodule

// File: rtl/idle_policy.sv
module idle_policy
  import idle_pkg::*;
(
  input  policy_e policy_i,
  input  logic    req_i,
  input  logic    quiet_i,
  input  logic    idle_q_i,
  output logic    idle_d_o
);
  always_comb begin
    idle_d_o = 1'b0;
    if (req_i) begin
      if (idle_q_i) idle_d_o = 1'b1;
      else begin
        unique case (policy_i)
          POL_FORCE: idle_d_o = 1'b1;
          POL_SMART: idle_d_o = quiet_i;
          default:   idle_d_o = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/idle_ack_ctrl.sv
module idle_ack_ctrl
  import idle_pkg::*;
#(
  parameter int unsigned CFG_W = 32,
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             idle_req_i,
  input  logic [N_IRQ-1:0] irq_i,
  output logic             idle_ack_o,
  output logic             idle_o
);
  policy_e policy;
  logic    quiet;
  logic    idle_d, idle_q;

  idle_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .policy_o (policy)
  );

  idle_irq_quiet #(.N_IRQ(N_IRQ)) u_quiet (
    .irq_i   (irq_i),
    .quiet_o (quiet)
  );

  idle_policy u_pol (
    .policy_i (policy),
    .req_i    (idle_req_i),
    .quiet_i  (quiet),
    .idle_q_i (idle_q),
    .idle_d_o (idle_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= 1'b0;
    else         idle_q <= idle_d;
  end

  assign idle_ack_o = idle_q;
  assign idle_o     = idle_q;

  a_r3_force_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy == POL_FORCE && idle_req_i) |=> idle_ack_o);
  a_r4_never_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((policy == POL_NEVER || policy == POL_RSVD) && !idle_ack_o) |=> !idle_ack_o);
  a_r5_smart_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy == POL_SMART && !idle_ack_o && (|irq_i)) |=> !idle_ack_o);
  a_r5_smart_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy == POL_SMART && idle_req_i && !(|irq_i)) |=> idle_ack_o);
  a_r7_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_req_i |=> !idle_ack_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && idle_req_i) |=> idle_ack_o);
endmodule

// File: tb/sim_idle_ack_ctrl.sv
module sim_idle_ack_ctrl;
  localparam int CFG_W = 32;
  localparam int N_IRQ = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             req = 1'b0;
  logic [N_IRQ-1:0] irq = '0;
  logic             ack, idle;

  int vectors = 0;
  int misses  = 0;
  int m_mode;
  int m_ack;

  always #5 clk = ~clk;

  idle_ack_ctrl #(.CFG_W(CFG_W), .N_IRQ(N_IRQ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .idle_req_i(req), .irq_i(irq), .idle_ack_o(ack), .idle_o(idle)
  );

  // behavioural reference, updated at every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1;
      m_ack  = 0;
    end else begin
      if (req == 1'b0)      m_ack = 0;
      else if (m_ack == 1)  m_ack = 1;
      else if (m_mode == 0) m_ack = 1;
      else if (m_mode == 2) m_ack = (irq == '0) ? 1 : 0;
      else                  m_ack = 0;
      if (cfg_we) m_mode = int'(cfg_wdata[3:2]);
    end
  end

  task automatic check(input string tag);
    vectors++;
    if (ack !== m_ack[0]) begin
      misses++;
      $display("FAIL %s: idle_ack_o=%0b expected %0b", tag, ack, m_ack[0]);
    end
    if (idle !== ack) begin
      misses++;
      $display("FAIL R10: idle_o=%0b expected %0b", idle, ack);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
      cfg_we = 1'b0;
    end
  endtask

  task automatic wr(input logic [CFG_W-1:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
  endtask

  initial begin
    #3_000_000;
    misses++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1;
    check("R1");
    #20 rst_n = 1'b1;
    run(1, "R1");
    req = 1'b1;                      // reset policy refuses
    run(4, "R1");
    req = 1'b0; run(1, "R7");

    wr(32'hFFFF_FFF7);               // policy 1 with other bits set (R2)
    run(1, "R2");
    req = 1'b1; irq = '0; run(5, "R4");
    irq = 8'h3C; run(3, "R4");
    req = 1'b0; run(1, "R7");

    wr(32'hFFFF_FFF3);               // policy 0 with other bits set (R2)
    run(1, "R2");
    irq = 8'hFF; req = 1'b1; run(4, "R3");
    req = 1'b0; run(2, "R7");
    req = 1'b1; run(2, "R3");
    req = 1'b0; irq = '0; run(1, "R7");

    wr(32'h0000_0008);               // policy 2
    run(1, "R2");
    irq = 8'h81; req = 1'b1; run(3, "R5");
    irq = 8'h80; run(3, "R5");
    irq = 8'h00; run(2, "R5");
    irq = 8'hFF; run(2, "R8");       // grant held despite interrupts
    wr(32'h0000_0004); run(3, "R8"); // grant held despite policy change
    req = 1'b0; run(1, "R7");

    wr(32'h0000_000C);               // policy 3
    irq = '0; run(1, "R2");
    req = 1'b1; run(5, "R6");
    irq = 8'h01; run(2, "R6");
    req = 1'b0; irq = '0; run(1, "R7");

    wr(32'h0000_0004);               // R9: waiting request rejudged
    req = 1'b1; run(3, "R9");
    wr(32'h0000_0000); run(1, "R9");
    run(2, "R9");
    req = 1'b0; run(1, "R7");
    wr(32'h0000_0004); irq = 8'h10; req = 1'b1; run(2, "R9");
    wr(32'h0000_0008); run(2, "R9");
    irq = '0; run(2, "R9");
    req = 1'b0; run(2, "R7");

    rst_n = 1'b0; #1;
    check("R1");
    #19 rst_n = 1'b1;
    req = 1'b1; run(3, "R1");
    req = 1'b0; run(1, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule